// File: doc/BRIEF.md
# DSP Address Generation Unit

This unit produces data-memory addresses for signal-processing loops such as FIR delay lines and FFT butterflies. It keeps a bank of eight address registers. Register 0 doubles as the step amount for step-based operations. Every cycle it accepts one operation. The operation selects a register, emits that register's current value as the access address, and may write an updated value back. The update is a post-modify: the address used for the access is always the value before the update.

The unit offers several update rules:
- linear increment, decrement and stepping;
- circular stepping inside a buffer given by a base and a size, done with a cheap mask when the size is a power of two and with a compare-and-correct otherwise;
- bit-reversed stepping, where the carry travels from the top bit toward bit 0, for FFT data reordering;
- indexed stepping by a second register;
- a direct load from a data input.

The new register value is presented on a writeback port so the surrounding datapath can track pointer updates. The memory itself lies outside this block.

Top module: `agu_top`

## Requirements
- R1: A synchronous active-high reset clears all eight registers to 0 and drives addrValid and wbValid low.
- R2: The read operations have no writeback and change no register. Opcode 1 emits register idxIn. Opcode 2 emits register 0. Opcode 0, and the unused code 15, emit nothing (addrValid low).
- R3: The linear operations write the result back into register idxIn and emit the old value. Opcode 3 adds 1, opcode 4 subtracts 1 and opcode 5 adds register 0. All three wrap modulo 2^16.
- R4: Opcode 6 adds 1 to register 0, emits register idxIn, and reports writeback index 0.
- R5: Circular operations move by 1 or by the step, and the result stays inside the buffer. Opcode 7 adds 1, opcode 8 subtracts 1, opcode 9 adds register 0 and opcode 10 subtracts register 0. When sizeIn is a power of two, the bits above log2(sizeIn) are kept and only the low bits wrap, in both directions.
- R6: When sizeIn is not a power of two, a circular result above baseIn+sizeIn-1 has sizeIn subtracted. A result below baseIn has sizeIn added.
- R7: Circular stepping by register 0 (opcodes 9 and 10) wraps in both directions, provided the step does not exceed sizeIn.
- R8: Opcode 11 adds register 0 to register idxIn with the carry moving from bit 15 toward bit 0. A carry out of bit 0 is dropped. A step of N/2 from 0 gives the bit-reversed order of an N-point FFT.
- R9: Opcode 12 adds register idx2In to register idxIn, and opcode 13 subtracts it. The old value is emitted.
- R10: Opcode 14 writes loadData into register idxIn. In the same cycle it emits the old value, and an access in the next cycle sees the new value.
- R11: Each operation shows its results in the cycle after it is presented, and operations may be issued back to back. Registers an operation does not target keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opIn | input | 4 | Operation code |
| idxIn | input | 3 | Register selected by the operation |
| idx2In | input | 3 | Register holding the index amount |
| baseIn | input | 16 | Circular buffer start address |
| sizeIn | input | 16 | Circular buffer length, at least 1 |
| loadData | input | 16 | Value for the load operation |
| addrOut | output | 16 | Address emitted (value before update) |
| addrValid | output | 1 | addrOut is meaningful |
| wbValid | output | 1 | A register was written |
| wbIdx | output | 3 | Index of the written register |
| wbData | output | 16 | New value of the written register |

## Verification
A corrupted register shows at addrOut the next time that register is selected, so the bench reads back every register at the end. A wrong wrap or carry direction shows at wbData in the very next cycle. It also disturbs the following addrOut in a chained sequence, which is why circular and bit-reversed runs are checked step by step against an independently computed order. A stray write to a register the operation does not target only appears on a later read, which the final sweep covers.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_NOP   = 4'd0;
  localparam logic [OPW-1:0] OP_RDA   = 4'd1;
  localparam logic [OPW-1:0] OP_RDS   = 4'd2;
  localparam logic [OPW-1:0] OP_INC   = 4'd3;
  localparam logic [OPW-1:0] OP_DEC   = 4'd4;
  localparam logic [OPW-1:0] OP_STEP  = 4'd5;
  localparam logic [OPW-1:0] OP_INCS  = 4'd6;
  localparam logic [OPW-1:0] OP_CINC  = 4'd7;
  localparam logic [OPW-1:0] OP_CDEC  = 4'd8;
  localparam logic [OPW-1:0] OP_CSTPP = 4'd9;
  localparam logic [OPW-1:0] OP_CSTPM = 4'd10;
  localparam logic [OPW-1:0] OP_BREV  = 4'd11;
  localparam logic [OPW-1:0] OP_IDXP  = 4'd12;
  localparam logic [OPW-1:0] OP_IDXM  = 4'd13;
  localparam logic [OPW-1:0] OP_LOAD  = 4'd14;

  typedef enum logic [1:0] {UPD_LIN, UPD_CIRC, UPD_BREV, UPD_LOAD} updMode_e;
  typedef enum logic [1:0] {DLT_ONE, DLT_STEP, DLT_IDX} dltSel_e;

  typedef struct packed {
    logic     opValid;
    logic     wrEn;
    logic     tgtStep;
    logic     outStep;
    logic     negate;
    updMode_e mode;
    dltSel_e  dlt;
  } aguCtl_t;
endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic [OPW-1:0] opIn,
  output aguCtl_t        ctl
);
  always_comb begin
    ctl = '0;
    ctl.mode = UPD_LIN;
    ctl.dlt = DLT_ONE;
    case (opIn)
      OP_RDA: ctl.opValid = 1'b1;
      OP_RDS: begin
        ctl.opValid = 1'b1;
        ctl.outStep = 1'b1;
      end
      OP_INC: begin
        ctl.opValid = 1'b1;
        ctl.wrEn = 1'b1;
      end
      OP_DEC: begin
        ctl.opValid = 1'b1;
        ctl.wrEn = 1'b1;
        ctl.negate = 1'b1;
      end
      OP_STEP: begin
        ctl.opValid = 1'b1;
        ctl.wrEn = 1'b1;
        ctl.dlt = DLT_STEP;
      end
      OP_INCS: begin
        ctl.opValid = 1'b1;
        ctl.wrEn = 1'b1;
        ctl.tgtStep = 1'b1;
      end
      OP_CINC: begin
        ctl.opValid = 1'b1;
        ctl.wrEn = 1'b1;
        ctl.mode = UPD_CIRC;
      end
      OP_CDEC: begin
        ctl.opValid = 1'b1;
        ctl.wrEn = 1'b1;
        ctl.mode = UPD_CIRC;
        ctl.negate = 1'b1;
      end
      OP_CSTPP: begin
        ctl.opValid = 1'b1;
        ctl.wrEn = 1'b1;
        ctl.mode = UPD_CIRC;
        ctl.dlt = DLT_STEP;
      end
      OP_CSTPM: begin
        ctl.opValid = 1'b1;
        ctl.wrEn = 1'b1;
        ctl.mode = UPD_CIRC;
        ctl.dlt = DLT_STEP;
        ctl.negate = 1'b1;
      end
      OP_BREV: begin
        ctl.opValid = 1'b1;
        ctl.wrEn = 1'b1;
        ctl.mode = UPD_BREV;
        ctl.dlt = DLT_STEP;
      end
      OP_IDXP: begin
        ctl.opValid = 1'b1;
        ctl.wrEn = 1'b1;
        ctl.dlt = DLT_IDX;
      end
      OP_IDXM: begin
        ctl.opValid = 1'b1;
        ctl.wrEn = 1'b1;
        ctl.dlt = DLT_IDX;
        ctl.negate = 1'b1;
      end
      OP_LOAD: begin
        ctl.opValid = 1'b1;
        ctl.wrEn = 1'b1;
        ctl.mode = UPD_LOAD;
      end
      default: ctl = ctl;
    endcase
  end
endmodule

// File: rtl/agu_circ.sv
module agu_circ #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] curIn,
  input  logic [AW-1:0] dltIn,
  input  logic          negIn,
  input  logic [AW-1:0] baseIn,
  input  logic [AW-1:0] sizeIn,
  output logic [AW-1:0] resOut
);
  logic [AW:0]   sumX;
  logic [AW:0]   lastAddr;
  logic [AW-1:0] mask;
  logic [AW-1:0] maskRes;
  logic [AW-1:0] cmpRes;
  logic          isPow2;
  logic          overTop;
  logic          underBase;

  always_comb begin
    if (negIn) sumX = {1'b0, curIn} - {1'b0, dltIn};
    else       sumX = {1'b0, curIn} + {1'b0, dltIn};
    mask     = sizeIn - {{(AW-1){1'b0}}, 1'b1};
    isPow2   = (sizeIn != '0) && ((sizeIn & mask) == '0);
    lastAddr = {1'b0, baseIn} + {1'b0, sizeIn} - {{AW{1'b0}}, 1'b1};
    maskRes  = (curIn & ~mask) | (sumX[AW-1:0] & mask);
    overTop  = !negIn && (sumX > lastAddr);
    underBase = negIn && (sumX[AW] || (sumX[AW-1:0] < baseIn));
    if (overTop)        cmpRes = sumX[AW-1:0] - sizeIn;
    else if (underBase) cmpRes = sumX[AW-1:0] + sizeIn;
    else                cmpRes = sumX[AW-1:0];
    resOut = isPow2 ? maskRes : cmpRes;
  end
endmodule

// File: rtl/agu_brev.sv
module agu_brev #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] curIn,
  input  logic [AW-1:0] stepIn,
  output logic [AW-1:0] resOut
);
  logic [AW-1:0] revCur;
  logic [AW-1:0] revStep;
  logic [AW-1:0] revSum;

  for (genvar g = 0; g < AW; g++) begin : g_mirror
    assign revCur[g]  = curIn[AW-1-g];
    assign revStep[g] = stepIn[AW-1-g];
    assign resOut[g]  = revSum[AW-1-g];
  end

  assign revSum = revCur + revStep;
endmodule

// File: rtl/agu_dpath.sv
module agu_dpath
  import agu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 8,
  parameter int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  aguCtl_t         ctl,
  input  logic [IDXW-1:0] idxIn,
  input  logic [IDXW-1:0] idx2In,
  input  logic [AW-1:0]   baseIn,
  input  logic [AW-1:0]   sizeIn,
  input  logic [AW-1:0]   loadData,
  output logic [AW-1:0]   addrOut,
  output logic            addrValid,
  output logic            wbValid,
  output logic [IDXW-1:0] wbIdx,
  output logic [AW-1:0]   wbData
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0]   arFile [NREG];
  logic [IDXW-1:0] tgtIdx;
  logic [AW-1:0]   stepVal;
  logic [AW-1:0]   srcVal;
  logic [AW-1:0]   opnd;
  logic [AW-1:0]   delta;
  logic [AW-1:0]   linRes;
  logic [AW-1:0]   circRes;
  logic [AW-1:0]   brevRes;
  logic [AW-1:0]   nextVal;

  always_comb begin
    stepVal = arFile[0];
    srcVal  = arFile[idxIn];
    tgtIdx  = ctl.tgtStep ? '0 : idxIn;
    opnd    = arFile[tgtIdx];
    case (ctl.dlt)
      DLT_STEP: delta = stepVal;
      DLT_IDX:  delta = arFile[idx2In];
      default:  delta = ONE;
    endcase
    linRes = ctl.negate ? (opnd - delta) : (opnd + delta);
  end

  agu_circ #(.AW(AW)) u_circ (
    .curIn (opnd),
    .dltIn (delta),
    .negIn (ctl.negate),
    .baseIn(baseIn),
    .sizeIn(sizeIn),
    .resOut(circRes)
  );

  agu_brev #(.AW(AW)) u_brev (
    .curIn (opnd),
    .stepIn(delta),
    .resOut(brevRes)
  );

  always_comb begin
    case (ctl.mode)
      UPD_CIRC: nextVal = circRes;
      UPD_BREV: nextVal = brevRes;
      UPD_LOAD: nextVal = loadData;
      default:  nextVal = linRes;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) arFile[i] <= '0;
      addrOut   <= '0;
      addrValid <= 1'b0;
      wbValid   <= 1'b0;
      wbIdx     <= '0;
      wbData    <= '0;
    end else begin
      if (ctl.wrEn) arFile[tgtIdx] <= nextVal;
      addrValid <= ctl.opValid;
      addrOut   <= ctl.outStep ? stepVal : srcVal;
      wbValid   <= ctl.wrEn;
      wbIdx     <= tgtIdx;
      wbData    <= nextVal;
    end
  end
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 8,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OPW-1:0]  opIn,
  input  logic [IDXW-1:0] idxIn,
  input  logic [IDXW-1:0] idx2In,
  input  logic [AW-1:0]   baseIn,
  input  logic [AW-1:0]   sizeIn,
  input  logic [AW-1:0]   loadData,
  output logic [AW-1:0]   addrOut,
  output logic            addrValid,
  output logic            wbValid,
  output logic [IDXW-1:0] wbIdx,
  output logic [AW-1:0]   wbData
);
  aguCtl_t ctl;

  agu_ctrl u_ctrl (
    .opIn(opIn),
    .ctl (ctl)
  );

  agu_dpath #(.AW(AW), .NREG(NREG), .IDXW(IDXW)) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .idxIn    (idxIn),
    .idx2In   (idx2In),
    .baseIn   (baseIn),
    .sizeIn   (sizeIn),
    .loadData (loadData),
    .addrOut  (addrOut),
    .addrValid(addrValid),
    .wbValid  (wbValid),
    .wbIdx    (wbIdx),
    .wbData   (wbData)
  );
endmodule

// File: rtl/agu_chk.sv
module agu_chk
  import agu_pkg::*;
#(
  parameter int AW   = 16,
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst,
  input logic [OPW-1:0]  opIn,
  input logic [IDXW-1:0] idxIn,
  input logic [AW-1:0]   baseIn,
  input logic [AW-1:0]   sizeIn,
  input logic [AW-1:0]   loadData,
  input logic [AW-1:0]   addrOut,
  input logic            addrValid,
  input logic            wbValid,
  input logic [IDXW-1:0] wbIdx,
  input logic [AW-1:0]   wbData
);
  logic            seen;
  logic [OPW-1:0]  prevOp;
  logic [IDXW-1:0] prevIdx;
  logic [AW-1:0]   prevBase;
  logic [AW-1:0]   prevSize;
  logic [AW-1:0]   prevLoad;
  logic [AW:0]     lastA;
  logic            oldIn;
  logic            newIn;
  logic            nonPow2;

  always_ff @(posedge clk) begin
    seen     <= !rst;
    prevOp   <= opIn;
    prevIdx  <= idxIn;
    prevBase <= baseIn;
    prevSize <= sizeIn;
    prevLoad <= loadData;
  end

  always_comb begin
    lastA   = {1'b0, prevBase} + {1'b0, prevSize} - {{AW{1'b0}}, 1'b1};
    oldIn   = (addrOut >= prevBase) && ({1'b0, addrOut} <= lastA);
    newIn   = (wbData >= prevBase) && ({1'b0, wbData} <= lastA);
    nonPow2 = (prevSize & (prevSize - {{(AW-1){1'b0}}, 1'b1})) != '0;
  end

  p_read_no_wb_r2: assert property (@(posedge clk) disable iff (rst)
    (seen && (prevOp == OP_RDA || prevOp == OP_RDS || prevOp == OP_NOP)) |-> !wbValid);

  p_inc_old_new_r3: assert property (@(posedge clk) disable iff (rst)
    (seen && prevOp == OP_INC) |-> (wbValid && wbData == addrOut + {{(AW-1){1'b0}}, 1'b1}));

  p_step_target_r4: assert property (@(posedge clk) disable iff (rst)
    (seen && prevOp == OP_INCS) |-> (wbValid && wbIdx == '0));

  p_circ_in_range_r6: assert property (@(posedge clk) disable iff (rst)
    (seen && (prevOp == OP_CINC || prevOp == OP_CDEC) && nonPow2 && oldIn) |-> newIn);

  p_load_value_r10: assert property (@(posedge clk) disable iff (rst)
    (seen && prevOp == OP_LOAD) |-> (wbValid && wbData == prevLoad && wbIdx == prevIdx));

  p_one_per_cycle_r11: assert property (@(posedge clk) disable iff (rst)
    (seen && prevOp != OP_NOP && prevOp != 4'd15) |-> addrValid);
endmodule

bind agu_top agu_chk #(.AW(AW), .IDXW(IDXW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opIn     (opIn),
  .idxIn    (idxIn),
  .baseIn   (baseIn),
  .sizeIn   (sizeIn),
  .loadData (loadData),
  .addrOut  (addrOut),
  .addrValid(addrValid),
  .wbValid  (wbValid),
  .wbIdx    (wbIdx),
  .wbData   (wbData)
);

// File: tb/sim_agu_top.sv
`timescale 1ns/1ps
module sim_agu_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  opIn = '0;
  logic [2:0]  idxIn = '0;
  logic [2:0]  idx2In = '0;
  logic [15:0] baseIn = '0;
  logic [15:0] sizeIn = 16'd1;
  logic [15:0] loadData = '0;
  logic [15:0] addrOut;
  logic        addrValid;
  logic        wbValid;
  logic [2:0]  wbIdx;
  logic [15:0] wbData;

  always #10 clk = ~clk;

  agu_top u0 (
    .clk(clk), .rst(rst), .opIn(opIn), .idxIn(idxIn), .idx2In(idx2In),
    .baseIn(baseIn), .sizeIn(sizeIn), .loadData(loadData),
    .addrOut(addrOut), .addrValid(addrValid), .wbValid(wbValid),
    .wbIdx(wbIdx), .wbData(wbData)
  );

  typedef struct packed {
    logic        av;
    logic [15:0] a;
    logic        wv;
    logic [2:0]  wi;
    logic [15:0] wd;
  } exp_t;

  exp_t  expQ[$];
  string tagQ[$];
  logic [15:0] mdl [8];
  int nChk = 0;
  int nFail = 0;
  logic done = 1'b0;

  function automatic logic [15:0] mCirc(input logic [15:0] cur, input logic [15:0] d,
                                        input logic neg, input logic [15:0] base,
                                        input logic [15:0] size);
    logic [15:0] m;
    int rel;
    m = size - 16'd1;
    if ((size & m) == 16'd0) begin
      return (cur & ~m) | ((neg ? cur - d : cur + d) & m);
    end
    rel = int'(cur) - int'(base);
    rel = neg ? rel - int'(d) : rel + int'(d);
    rel = ((rel % int'(size)) + int'(size)) % int'(size);
    return base + 16'(rel);
  endfunction

  function automatic logic [15:0] mRev(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  task automatic doOp(input logic [3:0] op, input int idx, input int idx2,
                      input logic [15:0] base, input logic [15:0] size,
                      input logic [15:0] ld, input string tag);
    exp_t e;
    logic [15:0] cur;
    logic [15:0] st;
    cur = mdl[idx];
    st  = mdl[0];
    e = '0;
    e.av = (op != 4'd0) && (op != 4'd15);
    e.a  = (op == 4'd2) ? st : cur;
    e.wv = 1'b1;
    e.wi = 3'(idx);
    case (op)
      4'd3:  e.wd = cur + 16'd1;
      4'd4:  e.wd = cur - 16'd1;
      4'd5:  e.wd = cur + st;
      4'd6:  begin e.wi = 3'd0; e.wd = st + 16'd1; end
      4'd7:  e.wd = mCirc(cur, 16'd1, 1'b0, base, size);
      4'd8:  e.wd = mCirc(cur, 16'd1, 1'b1, base, size);
      4'd9:  e.wd = mCirc(cur, st, 1'b0, base, size);
      4'd10: e.wd = mCirc(cur, st, 1'b1, base, size);
      4'd11: e.wd = mRev(mRev(cur) + mRev(st));
      4'd12: e.wd = cur + mdl[idx2];
      4'd13: e.wd = cur - mdl[idx2];
      4'd14: e.wd = ld;
      default: e.wv = 1'b0;
    endcase
    @(negedge clk);
    opIn = op; idxIn = 3'(idx); idx2In = 3'(idx2);
    baseIn = base; sizeIn = size; loadData = ld;
    expQ.push_back(e);
    tagQ.push_back(tag);
    if (e.wv) mdl[e.wi] = e.wd;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) doOp(4'd0, 0, 0, 16'd0, 16'd1, 16'd0, "R2");
  endtask

  // scoreboard monitor
  always begin
    exp_t e;
    string t;
    logic ok;
    @(posedge clk);
    #5;
    if (expQ.size() > 0) begin
      e = expQ.pop_front();
      t = tagQ.pop_front();
      ok = (addrValid == e.av) && (!e.av || addrOut == e.a) &&
           (wbValid == e.wv) && (!e.wv || (wbIdx == e.wi && wbData == e.wd));
      nChk++;
      if (!ok) begin
        nFail++;
        $display("FAIL %s: got av=%b a=%0d wv=%b wi=%0d wd=%0d, expected av=%b a=%0d wv=%b wi=%0d wd=%0d",
                 t, addrValid, addrOut, wbValid, wbIdx, wbData, e.av, e.a, e.wv, e.wi, e.wd);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFail++;
      nChk++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet while in reset
    nChk++;
    if (addrValid !== 1'b0 || wbValid !== 1'b0) begin
      nFail++;
      $display("FAIL R1: got av=%b wv=%b, expected av=0 wv=0", addrValid, wbValid);
    end
    rst = 1'b0;
    doOp(4'd1, 3, 0, 16'd0, 16'd1, 16'd0, "R1");
    doOp(4'd1, 7, 0, 16'd0, 16'd1, 16'd0, "R1");
    // R10: load emits old value, next access sees new
    doOp(4'd14, 1, 0, 16'd0, 16'd1, 16'd100, "R10");
    doOp(4'd1, 1, 0, 16'd0, 16'd1, 16'd0, "R10");
    doOp(4'd14, 0, 0, 16'd0, 16'd1, 16'd3, "R10");
    // R2: reads with no writeback, unused code ignored
    doOp(4'd2, 5, 0, 16'd0, 16'd1, 16'd0, "R2");
    doOp(4'd15, 1, 0, 16'd0, 16'd1, 16'd77, "R2");
    doOp(4'd1, 1, 0, 16'd0, 16'd1, 16'd0, "R2");
    // R3: linear post-modify
    doOp(4'd3, 1, 0, 16'd0, 16'd1, 16'd0, "R3");
    doOp(4'd4, 1, 0, 16'd0, 16'd1, 16'd0, "R3");
    doOp(4'd5, 1, 0, 16'd0, 16'd1, 16'd0, "R3");
    doOp(4'd4, 7, 0, 16'd0, 16'd1, 16'd0, "R3");
    // R4: step register increment
    doOp(4'd6, 1, 0, 16'd0, 16'd1, 16'd0, "R4");
    doOp(4'd2, 0, 0, 16'd0, 16'd1, 16'd0, "R4");
    // R5: power-of-two buffer, base 32 size 8, both directions
    doOp(4'd14, 2, 0, 16'd0, 16'd1, 16'd38, "R5");
    doOp(4'd7, 2, 0, 16'd32, 16'd8, 16'd0, "R5");
    doOp(4'd7, 2, 0, 16'd32, 16'd8, 16'd0, "R5");
    doOp(4'd8, 2, 0, 16'd32, 16'd8, 16'd0, "R5");
    doOp(4'd8, 2, 0, 16'd32, 16'd8, 16'd0, "R5");
    // R6: odd size buffer, base 10 size 5
    doOp(4'd14, 3, 0, 16'd0, 16'd1, 16'd14, "R6");
    doOp(4'd7, 3, 0, 16'd10, 16'd5, 16'd0, "R6");
    doOp(4'd8, 3, 0, 16'd10, 16'd5, 16'd0, "R6");
    doOp(4'd8, 3, 0, 16'd10, 16'd5, 16'd0, "R6");
    // R7: circular step by 3 inside base 10 size 5
    doOp(4'd14, 0, 0, 16'd0, 16'd1, 16'd3, "R7");
    doOp(4'd14, 3, 0, 16'd0, 16'd1, 16'd13, "R7");
    doOp(4'd9, 3, 0, 16'd10, 16'd5, 16'd0, "R7");
    doOp(4'd10, 3, 0, 16'd10, 16'd5, 16'd0, "R7");
    doOp(4'd10, 3, 0, 16'd10, 16'd5, 16'd0, "R7");
    doOp(4'd10, 3, 0, 16'd10, 16'd5, 16'd0, "R7");
    doOp(4'd9, 2, 0, 16'd32, 16'd8, 16'd0, "R7");
    // R8: 8-point bit-reversed order
    doOp(4'd14, 0, 0, 16'd0, 16'd1, 16'd4, "R8");
    doOp(4'd14, 4, 0, 16'd0, 16'd1, 16'd0, "R8");
    for (int k = 0; k < 9; k++) doOp(4'd11, 4, 0, 16'd0, 16'd1, 16'd0, "R8");
    // R8: 16-point bit-reversed order on a buffer at 0x40
    doOp(4'd14, 0, 0, 16'd0, 16'd1, 16'd8, "R8");
    doOp(4'd14, 4, 0, 16'd0, 16'd1, 16'h0040, "R8");
    for (int k = 0; k < 17; k++) doOp(4'd11, 4, 0, 16'd0, 16'd1, 16'd0, "R8");
    // R9: indexed step
    doOp(4'd14, 5, 0, 16'd0, 16'd1, 16'd50, "R9");
    doOp(4'd14, 6, 0, 16'd0, 16'd1, 16'd7, "R9");
    doOp(4'd12, 5, 6, 16'd0, 16'd1, 16'd0, "R9");
    doOp(4'd13, 5, 6, 16'd0, 16'd1, 16'd0, "R9");
    doOp(4'd13, 5, 6, 16'd0, 16'd1, 16'd0, "R9");
    // R11: sweep every register after back-to-back traffic
    for (int k = 0; k < 8; k++) doOp(4'd1, k, 0, 16'd0, 16'd1, 16'd0, "R11");
    nop(3);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule